// File: doc/BRIEF.md
# Five-State Sequence Counter

A 3-bit synchronous counter that walks a fixed, non-binary loop of five codes, advancing once on every rising clock edge. The loop runs 000, 100, 111, 010, 011 and then back to 000. The codes 001, 101 and 110 never occur in normal operation. If one of them is ever reached, the counter returns to 000 on the next edge, so it can never lock up.

An active-low asynchronous clear forces the counter to 000 at any time. The next state comes from a per-bit toggle vector: each output bit flips when its toggle bit is set. A test-only synchronous preload lets a bench place any code, including the unused ones, into the register. This is how the recovery path is exercised.

Top module: `seq5_counter`

## Requirements
- R1: While `clr_n` is low the output `state` is 000, and it becomes 000 as soon as `clr_n` falls, without waiting for a clock edge.
- R2: With `load_en` low, state 000 advances to 100 on the next rising clock edge.
- R3: With `load_en` low, state 100 advances to 111 on the next rising clock edge.
- R4: With `load_en` low, state 111 advances to 010 on the next rising clock edge.
- R5: With `load_en` low, state 010 advances to 011 on the next rising clock edge.
- R6: With `load_en` low, state 011 returns to 000 on the next rising clock edge, which closes a loop of period five.
- R7: With `load_en` low, each unused code (001, 101, 110) goes to 000 on the next rising clock edge.
- R8: With `load_en` high and `clr_n` high, `state` takes the value of `load_val` on the next rising clock edge. This overrides the normal step for every code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low, forces 000 |
| load_en | input | 1 | Test-only synchronous preload enable |
| load_val | input | 3 | Code loaded when `load_en` is high |
| state | output | 3 | Current counter code, bit 2 = C, bit 0 = A |

## Verification
The bench preloads each of the three unused codes and checks that the next edge yields 000. A design that left them unhandled would sit in a stuck loop or drift into a wrong member of the cycle. It also runs a full loop to confirm the order of all five codes. A design with one wrong toggle bit would skip a code, repeat one, or leave the loop for an unused code. Clear is asserted between clock edges, so a design that cleared only on the clock would be caught. Random preloads that land on the same cycle as a would-be step confirm that the preload wins.

// File: rtl/seq5_counter.sv
module seq5_counter (
  input  logic       clk,
  input  logic       clr_n,
  input  logic       load_en,
  input  logic [2:0] load_val,
  output logic [2:0] state
);

  logic [2:0] tgl;
  logic [2:0] step_nxt;

  always_comb begin
    case (state)
      3'b000:  tgl = 3'b100;
      3'b100:  tgl = 3'b011;
      3'b111:  tgl = 3'b101;
      3'b010:  tgl = 3'b001;
      3'b011:  tgl = 3'b011;
      default: tgl = state;
    endcase
  end

  assign step_nxt = state ^ tgl;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)
      state <= 3'b000;
    else if (load_en)
      state <= load_val;
    else
      state <= step_nxt;
  end

endmodule

// File: rtl/seq5_counter_chk.sv
module seq5_counter_chk (
  input logic       clk,
  input logic       clr_n,
  input logic       load_en,
  input logic [2:0] load_val,
  input logic [2:0] state
);

  AST_CLEAR_ZERO: assert property (@(posedge clk) !clr_n |-> state == 3'b000); // R1
  AST_STEP_000: assert property (@(posedge clk) disable iff (!clr_n) (!load_en && state == 3'b000) |=> state == 3'b100); // R2
  AST_STEP_100: assert property (@(posedge clk) disable iff (!clr_n) (!load_en && state == 3'b100) |=> state == 3'b111); // R3
  AST_STEP_111: assert property (@(posedge clk) disable iff (!clr_n) (!load_en && state == 3'b111) |=> state == 3'b010); // R4
  AST_STEP_010: assert property (@(posedge clk) disable iff (!clr_n) (!load_en && state == 3'b010) |=> state == 3'b011); // R5
  AST_STEP_011: assert property (@(posedge clk) disable iff (!clr_n) (!load_en && state == 3'b011) |=> state == 3'b000); // R6
  AST_UNUSED_RECOVER: assert property (@(posedge clk) disable iff (!clr_n) (!load_en && (state == 3'b001 || state == 3'b101 || state == 3'b110)) |=> state == 3'b000); // R7
  AST_PRELOAD: assert property (@(posedge clk) disable iff (!clr_n) load_en |=> state == $past(load_val)); // R8

endmodule

bind seq5_counter seq5_counter_chk u_chk (.*);

// File: tb/sim_seq5_counter.sv
module sim_seq5_counter;

  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       load_en = 1'b0;
  logic [2:0] load_val = 3'b000;
  logic [2:0] state;

  int checks = 0;
  int errors = 0;
  logic [2:0] exp_s;
  bit done = 1'b0;

  always #5 clk = ~clk;

  seq5_counter u0 (
    .clk(clk), .clr_n(clr_n), .load_en(load_en),
    .load_val(load_val), .state(state)
  );

  function automatic logic [2:0] model_next(input logic [2:0] s);
    case (s)
      3'b000: return 3'b100;
      3'b100: return 3'b111;
      3'b111: return 3'b010;
      3'b010: return 3'b011;
      3'b011: return 3'b000;
      default: return 3'b000;
    endcase
  endfunction

  function automatic string req_tag(input logic le, input logic [2:0] s);
    if (le) return "R8";
    case (s)
      3'b000: return "R2";
      3'b100: return "R3";
      3'b111: return "R4";
      3'b010: return "R5";
      3'b011: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [2:0] exp);
    checks++;
    if (state !== exp) begin
      errors++;
      $display("FAIL %s state=%b expected=%b", tag, state, exp);
    end
  endtask

  task automatic cycle(input logic le, input logic [2:0] lv);
    string tag;
    tag = req_tag(le, exp_s);
    load_en = le;
    load_val = lv;
    exp_s = le ? lv : model_next(exp_s);
    @(posedge clk);
    @(negedge clk);
    check(tag, exp_s);
  endtask

  initial begin
    process::self().srandom(32'd1234);
    exp_s = 3'b000;
    @(negedge clk);
    check("R1", 3'b000);
    @(negedge clk);
    clr_n = 1'b1;
    for (int i = 0; i < 10; i++) cycle(1'b0, 3'b000);
    cycle(1'b1, 3'b001); cycle(1'b0, 3'b000);
    cycle(1'b1, 3'b101); cycle(1'b0, 3'b000);
    cycle(1'b1, 3'b110); cycle(1'b0, 3'b000);
    cycle(1'b1, 3'b111); cycle(1'b0, 3'b000);
    cycle(1'b1, 3'b010);
    #2 clr_n = 1'b0;
    #1 exp_s = 3'b000;
    check("R1", 3'b000);
    @(posedge clk);
    @(negedge clk);
    check("R1", 3'b000);
    clr_n = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic le;
      le = ($urandom_range(0, 3) == 0);
      cycle(le, 3'($urandom_range(0, 7)));
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule